// File: doc/BRIEF.md
# Core-First Supply Sequencing Controller

This block drives the enables of three external supply switches: a primary rail (H), an I/O rail (M) and a core rail (L). On power-up the core switch always closes first and the I/O switch follows. On power-down the I/O switch opens first and the core switch opens last. The block takes three undervoltage-good flags, two sequence-trigger inputs, a feedback comparator flag, a primary-switch enable and a two-bit software shutdown code. It produces a power-good READY, the three enables and three status bits that mirror the commanded enables. Every asynchronous input passes through a two-flop synchronizer. All delays are counted in clock cycles and set by parameters.

A static mode input selects the trigger. In time mode, edges on the enable-sequence input start and stop the sequence, and a fixed up-delay separates the core and I/O turn-on. In voltage mode, edges on the set-voltage input start and stop the sequence, and the I/O switch waits for the feedback flag, which reports that the core rail has passed its reference. A rising trigger edge is latched as a standing request. The request is cleared only by a falling trigger edge, so the sequence resumes by itself after a fault or a software override ends.

Top module: `supply_seq_ctrl`

## Requirements
- R1: `ready` rises exactly 2+PURST_CYC cycles after `primaryGood` goes high and stays high. It falls 2 cycles after `primaryGood` goes low.
- R2: `gateH` equals the synchronized `primGateEn` AND `primaryGood`, and is forced low while `shutCode` is 2 or 3. The synchronized path has a latency of 3 cycles; the `shutCode` path has a latency of 1 cycle.
- R3: In time mode (`voltMode`=0), a rising `ensIn` sets `gateL` 4 cycles later, and `gateM` follows UP_CYC cycles after `gateL`. `gateM` is never high while `gateL` is low.
- R4: In time mode, a falling `ensIn` clears `gateM` 4 cycles later, and `gateL` follows DN_CYC cycles after that.
- R5: In voltage mode (`voltMode`=1), a rising `setvIn` sets `gateL` 4 cycles later. `gateM` stays low while `fbAboveRef` is low and rises 3 cycles after `fbAboveRef` goes high.
- R6: In voltage mode, a falling `setvIn` clears `gateM` 4 cycles later and `gateL` DN_CYC cycles after that.
- R7: When `primaryGood` falls, `gateH`, `gateM` and `gateL` all clear in the same cycle, 3 cycles after the change.
- R8: When `ioGood` falls, `gateM` clears 3 cycles later and `gateL` clears DN_CYC cycles after that.
- R9: When `coreGood` falls, `gateM` and `gateL` clear together 3 cycles later. This immediate shutdown wins over any orderly shutdown that is in progress.
- R10: `gateM` and `gateL` are set only while `ready`, `ioGood` and `coreGood` hold. A latched request restarts the sequence once all three hold again.
- R11: `shutCode` 1 clears `gateM` after 1 cycle and `gateL` DN_CYC cycles later. Code 3 does the same and also clears `gateH` together with `gateM`. Code 0 releases the override: `gateH` and `gateL` return after 1 cycle and `gateM` follows the mode rule.
- R12: `statH`, `statM` and `statL` always equal `gateH`, `gateM` and `gateL`. All outputs are 0 after reset.
- R13: A rising trigger edge that arrives during a pending core turn-off delay takes effect only after `gateL` has been low for one cycle.
- R14: The trigger input of the mode that is not selected has no effect on the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| voltMode | input | 1 | 0 = time mode, 1 = voltage mode (static) |
| shutCode | input | 2 | Software shutdown code, 0 = no override |
| primaryGood | input | 1 | Primary rail above lockout (async) |
| ioGood | input | 1 | I/O rail above lockout (async) |
| coreGood | input | 1 | Core rail above lockout (async) |
| ensIn | input | 1 | Time-mode sequence trigger (async) |
| setvIn | input | 1 | Voltage-mode sequence trigger (async) |
| fbAboveRef | input | 1 | Core feedback above reference (async) |
| primGateEn | input | 1 | External enable for the primary switch (async) |
| ready | output | 1 | Primary power-good after the reset delay |
| gateH | output | 1 | Primary switch enable |
| gateM | output | 1 | I/O switch enable |
| gateL | output | 1 | Core switch enable |
| statH | output | 1 | Status: commanded primary enable |
| statM | output | 1 | Status: commanded I/O enable |
| statL | output | 1 | Status: commanded core enable |

## Verification
Two turn-off paths can reach the control state machine in the same cycle: an orderly shutdown, which holds the core switch for the down-delay, and a core-rail fault, which drops both switches at once. The bench drops `coreGood` and then applies shutdown code 1 two cycles later. Because the fault path is synchronized and the code path is not, both reach the state machine on the same edge. The result is judged correct only if `gateL` and `gateM` clear together on that edge rather than `gateL` lingering for the down-delay.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_CORE_UP = 2'd1,
    ST_BOTH    = 2'd2,
    ST_DRAIN   = 2'd3
  } seqState_t;

  // strobes from control to datapath: restart the up or down delay counter
  typedef struct packed {
    logic upLoad;
    logic dnLoad;
  } seqStrobe_t;

  localparam logic [1:0] SHUT_NONE    = 2'd0;
  localparam logic [1:0] SHUT_IO_CORE = 2'd1;
  localparam logic [1:0] SHUT_PRIM    = 2'd2;
  localparam logic [1:0] SHUT_ALL     = 2'd3;

  // index of each asynchronous input in the synchronizer bank
  localparam int SIG_PRIM = 0;
  localparam int SIG_IO   = 1;
  localparam int SIG_CORE = 2;
  localparam int SIG_ENS  = 3;
  localparam int SIG_SETV = 4;
  localparam int SIG_FB   = 5;
  localparam int SIG_HEN  = 6;
  localparam int NUM_SIG  = 7;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PURST_CYC   = 64,
  parameter int UP_CYC      = 24,
  parameter int DN_CYC      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SIG-1:0] rawIn,
  input  seqStrobe_t         strobe,
  output logic               primOk,
  output logic               ioOk,
  output logic               coreOk,
  output logic               hEnOk,
  output logic               fbOk,
  output logic               ensRise,
  output logic               ensFall,
  output logic               setvRise,
  output logic               setvFall,
  output logic               ready,
  output logic               upDone,
  output logic               dnDone
);

  localparam int RW = $clog2(PURST_CYC + 1);
  localparam logic [RW-1:0] PURST_MAX = RW'(PURST_CYC);
  localparam int DMAX = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
  localparam int CW = $clog2(DMAX + 1);

  logic [NUM_SIG-1:0] syncd;

  // two-or-more flop synchronizer per asynchronous input
  for (genvar i = 0; i < NUM_SIG; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk) begin
      if (!rstN) shReg <= '0;
      else       shReg <= {shReg[SYNC_STAGES-2:0], rawIn[i]};
    end
    assign syncd[i] = shReg[SYNC_STAGES-1];
  end

  assign primOk = syncd[SIG_PRIM];
  assign ioOk   = syncd[SIG_IO];
  assign coreOk = syncd[SIG_CORE];
  assign hEnOk  = syncd[SIG_HEN];
  assign fbOk   = syncd[SIG_FB];

  // edge detection on the two trigger inputs
  logic ensPrev, setvPrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ensPrev  <= 1'b0;
      setvPrev <= 1'b0;
    end else begin
      ensPrev  <= syncd[SIG_ENS];
      setvPrev <= syncd[SIG_SETV];
    end
  end
  assign ensRise  =  syncd[SIG_ENS]  & ~ensPrev;
  assign ensFall  = ~syncd[SIG_ENS]  &  ensPrev;
  assign setvRise =  syncd[SIG_SETV] & ~setvPrev;
  assign setvFall = ~syncd[SIG_SETV] &  setvPrev;

  // power-up reset delay on the primary rail
  logic [RW-1:0] rstCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !primOk)        rstCnt <= '0;
    else if (rstCnt != PURST_MAX) rstCnt <= rstCnt + 1'b1;
  end
  assign ready = primOk && (rstCnt == PURST_MAX);

  // up (index 0) and down (index 1) delay counters, loaded with length-1
  logic [1:0] cntZero;
  for (genvar k = 0; k < 2; k++) begin : g_dly
    localparam logic [CW-1:0] LOADV = CW'(((k == 0) ? UP_CYC : DN_CYC) - 1);
    logic [CW-1:0] cnt;
    logic          load;
    assign load = (k == 0) ? strobe.upLoad : strobe.dnLoad;
    always_ff @(posedge clk) begin
      if (!rstN)          cnt <= '0;
      else if (load)      cnt <= LOADV;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
    assign cntZero[k] = (cnt == '0);
  end
  assign upDone = cntZero[0];
  assign dnDone = cntZero[1];

  // R1: once ready, it stays ready for as long as the primary stays good
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ready && primOk) |=> (ready || !primOk));

  // R1: ready can only rise after the primary was already good a cycle earlier
  a_r1_ready_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(primOk));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       voltMode,
  input  logic [1:0] shutCode,
  input  logic       primOk,
  input  logic       ioOk,
  input  logic       coreOk,
  input  logic       hEnOk,
  input  logic       fbOk,
  input  logic       ensRise,
  input  logic       ensFall,
  input  logic       setvRise,
  input  logic       setvFall,
  input  logic       ready,
  input  logic       upDone,
  input  logic       dnDone,
  output seqStrobe_t strobe,
  output logic       gateH,
  output logic       gateM,
  output logic       gateL
);

  seqState_t state, stateNext;
  logic seqOn;
  logic trigRise, trigFall, softStop, hardKill, permit, stepUp, hOff;

  assign trigRise = voltMode ? setvRise : ensRise;
  assign trigFall = voltMode ? setvFall : ensFall;
  assign softStop = (shutCode == SHUT_IO_CORE) || (shutCode == SHUT_ALL);
  assign hOff     = (shutCode == SHUT_PRIM)    || (shutCode == SHUT_ALL);
  assign hardKill = !ready || !coreOk;
  assign permit   = seqOn && ready && ioOk && coreOk && !softStop;
  assign stepUp   = voltMode ? fbOk : upDone;

  // standing sequence request, set by a rising and cleared by a falling trigger
  always_ff @(posedge clk) begin
    if (!rstN)         seqOn <= 1'b0;
    else if (trigRise) seqOn <= 1'b1;
    else if (trigFall) seqOn <= 1'b0;
  end

  always_comb begin
    stateNext     = state;
    strobe.upLoad = 1'b0;
    strobe.dnLoad = 1'b0;
    case (state)
      ST_OFF: begin
        if (permit) begin
          stateNext     = ST_CORE_UP;
          strobe.upLoad = 1'b1;
        end
      end
      ST_CORE_UP: begin
        if (hardKill) stateNext = ST_OFF;
        else if (!permit) begin
          stateNext     = ST_DRAIN;
          strobe.dnLoad = 1'b1;
        end else if (stepUp) stateNext = ST_BOTH;
      end
      ST_BOTH: begin
        if (hardKill) stateNext = ST_OFF;
        else if (!permit) begin
          stateNext     = ST_DRAIN;
          strobe.dnLoad = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (hardKill || dnDone) stateNext = ST_OFF;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OFF;
      gateH <= 1'b0;
    end else begin
      state <= stateNext;
      gateH <= hEnOk && primOk && !hOff;
    end
  end

  assign gateM = (state == ST_BOTH);
  assign gateL = (state != ST_OFF);

  // R3: the I/O enable is never on without the core enable
  a_r3_core_first: assert property (@(posedge clk) disable iff (!rstN)
    gateM |-> gateL);

  // R3: the I/O enable rises only after the core enable was already on
  a_r3_m_after_l: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateM) |-> $past(gateL));

  // R10: losing ready removes both sequenced enables on the next edge
  a_r10_ready_gate: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> (!gateL && !gateM));

  // R9: a core fault drops the core enable at once
  a_r9_core_kill: assert property (@(posedge clk) disable iff (!rstN)
    !coreOk |=> !gateL);

  // R2: codes 2 and 3 force the primary enable low
  a_r2_shut_h: assert property (@(posedge clk) disable iff (!rstN)
    ((shutCode == SHUT_PRIM) || (shutCode == SHUT_ALL)) |=> !gateH);

endmodule

// File: rtl/supply_seq_ctrl.sv
module supply_seq_ctrl
  import seq_pkg::*;
#(
  parameter int PURST_CYC   = 64,
  parameter int UP_CYC      = 24,
  parameter int DN_CYC      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       voltMode,
  input  logic [1:0] shutCode,
  input  logic       primaryGood,
  input  logic       ioGood,
  input  logic       coreGood,
  input  logic       ensIn,
  input  logic       setvIn,
  input  logic       fbAboveRef,
  input  logic       primGateEn,
  output logic       ready,
  output logic       gateH,
  output logic       gateM,
  output logic       gateL,
  output logic       statH,
  output logic       statM,
  output logic       statL
);

  logic [NUM_SIG-1:0] rawIn;
  seqStrobe_t strobe;
  logic primOk, ioOk, coreOk, hEnOk, fbOk;
  logic ensRise, ensFall, setvRise, setvFall, upDone, dnDone;

  always_comb begin
    rawIn           = '0;
    rawIn[SIG_PRIM] = primaryGood;
    rawIn[SIG_IO]   = ioGood;
    rawIn[SIG_CORE] = coreGood;
    rawIn[SIG_ENS]  = ensIn;
    rawIn[SIG_SETV] = setvIn;
    rawIn[SIG_FB]   = fbAboveRef;
    rawIn[SIG_HEN]  = primGateEn;
  end

  seq_datapath #(
    .PURST_CYC(PURST_CYC), .UP_CYC(UP_CYC), .DN_CYC(DN_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .strobe(strobe),
    .primOk(primOk), .ioOk(ioOk), .coreOk(coreOk), .hEnOk(hEnOk), .fbOk(fbOk),
    .ensRise(ensRise), .ensFall(ensFall), .setvRise(setvRise), .setvFall(setvFall),
    .ready(ready), .upDone(upDone), .dnDone(dnDone)
  );

  seq_control u_ctl (
    .clk(clk), .rstN(rstN), .voltMode(voltMode), .shutCode(shutCode),
    .primOk(primOk), .ioOk(ioOk), .coreOk(coreOk), .hEnOk(hEnOk), .fbOk(fbOk),
    .ensRise(ensRise), .ensFall(ensFall), .setvRise(setvRise), .setvFall(setvFall),
    .ready(ready), .upDone(upDone), .dnDone(dnDone), .strobe(strobe),
    .gateH(gateH), .gateM(gateM), .gateL(gateL)
  );

  // status bits mirror the commanded enables
  assign statH = gateH;
  assign statM = gateM;
  assign statL = gateL;

endmodule

// File: tb/tb_supply_seq_ctrl.sv
`timescale 1ns/1ps
module tb_supply_seq_ctrl;

  localparam int PURST = 16;
  localparam int UP    = 8;
  localparam int DN    = 6;

  logic clk = 1'b0;
  logic rstN;
  logic voltMode;
  logic [1:0] shutCode;
  logic primaryGood, ioGood, coreGood, ensIn, setvIn, fbAboveRef, primGateEn;
  logic ready, gateH, gateM, gateL, statH, statM, statL;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supply_seq_ctrl #(.PURST_CYC(PURST), .UP_CYC(UP), .DN_CYC(DN), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .voltMode(voltMode), .shutCode(shutCode),
    .primaryGood(primaryGood), .ioGood(ioGood), .coreGood(coreGood),
    .ensIn(ensIn), .setvIn(setvIn), .fbAboveRef(fbAboveRef), .primGateEn(primGateEn),
    .ready(ready), .gateH(gateH), .gateM(gateM), .gateL(gateL),
    .statH(statH), .statM(statM), .statL(statL)
  );

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // gates plus their status mirrors (R12)
  task automatic chkG(input string req, input logic h, input logic m, input logic l);
    chk(req, "gateH", gateH, h);
    chk(req, "gateM", gateM, m);
    chk(req, "gateL", gateL, l);
    chk("R12", "statH", statH, h);
    chk("R12", "statM", statM, m);
    chk("R12", "statL", statL, l);
  endtask

  task automatic tReset();
    chk("R12", "ready", ready, 1'b0);
    chkG("R12", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic tReady();
    primaryGood = 1'b1; ioGood = 1'b1; coreGood = 1'b1;
    waitEdges(2 + PURST - 1); chk("R1", "ready early", ready, 1'b0);
    waitEdges(1);             chk("R1", "ready on", ready, 1'b1);
  endtask

  task automatic tGateH();
    primGateEn = 1'b1;
    waitEdges(2); chk("R2", "gateH early", gateH, 1'b0);
    waitEdges(1); chk("R2", "gateH on", gateH, 1'b1);
  endtask

  task automatic tTimeUp();
    ensIn = 1'b1;
    waitEdges(3);      chkG("R3", 1'b1, 1'b0, 1'b0);
    waitEdges(1);      chkG("R3", 1'b1, 1'b0, 1'b1);
    waitEdges(UP - 1); chkG("R3", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R3", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tTimeDown();
    ensIn = 1'b0;
    waitEdges(3);      chkG("R4", 1'b1, 1'b1, 1'b1);
    waitEdges(1);      chkG("R4", 1'b1, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R4", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R4", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic tPending();
    ensIn = 1'b1;
    waitEdges(4 + UP + 2); chkG("R13", 1'b1, 1'b1, 1'b1);
    ensIn = 1'b0;
    waitEdges(2);
    ensIn = 1'b1;
    waitEdges(2);      chkG("R13", 1'b1, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R13", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R13", 1'b1, 1'b0, 1'b0);
    waitEdges(1);      chkG("R13", 1'b1, 1'b0, 1'b1);
    waitEdges(UP);     chkG("R13", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tCodes();
    shutCode = 2'd1;
    waitEdges(1);      chkG("R11", 1'b1, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R11", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R11", 1'b1, 1'b0, 1'b0);
    shutCode = 2'd0;
    waitEdges(1);      chkG("R11", 1'b1, 1'b0, 1'b1);
    waitEdges(UP - 1); chkG("R11", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R11", 1'b1, 1'b1, 1'b1);
    shutCode = 2'd2;
    waitEdges(1);      chkG("R2", 1'b0, 1'b1, 1'b1);
    shutCode = 2'd0;
    waitEdges(1);      chkG("R2", 1'b1, 1'b1, 1'b1);
    shutCode = 2'd3;
    waitEdges(1);      chkG("R11", 1'b0, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R11", 1'b0, 1'b0, 1'b1);
    waitEdges(1);      chkG("R11", 1'b0, 1'b0, 1'b0);
    shutCode = 2'd0;
    waitEdges(1);      chkG("R11", 1'b1, 1'b0, 1'b1);
    waitEdges(UP);     chkG("R11", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tIoFail();
    ioGood = 1'b0;
    waitEdges(2);      chkG("R8", 1'b1, 1'b1, 1'b1);
    waitEdges(1);      chkG("R8", 1'b1, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R8", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R8", 1'b1, 1'b0, 1'b0);
    ioGood = 1'b1;
    waitEdges(2);      chkG("R10", 1'b1, 1'b0, 1'b0);
    waitEdges(1);      chkG("R10", 1'b1, 1'b0, 1'b1);
    waitEdges(UP);     chkG("R10", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tCoreFail();
    coreGood = 1'b0;
    waitEdges(2);      chkG("R9", 1'b1, 1'b1, 1'b1);
    waitEdges(1);      chkG("R9", 1'b1, 1'b0, 1'b0);
    coreGood = 1'b1;
    waitEdges(3 + UP); chkG("R10", 1'b1, 1'b1, 1'b1);
  endtask

  // core fault and shutdown code 1 reach the control logic on the same edge
  task automatic tCollision();
    coreGood = 1'b0;
    waitEdges(2);
    shutCode = 2'd1;
    waitEdges(1);      chkG("R9", 1'b1, 1'b0, 1'b0);
    waitEdges(DN);     chkG("R9", 1'b1, 1'b0, 1'b0);
    coreGood = 1'b1;
    shutCode = 2'd0;
    waitEdges(3 + UP); chkG("R11", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tPrimFail();
    primaryGood = 1'b0;
    waitEdges(2);
    chk("R1", "ready drop", ready, 1'b0);
    chkG("R7", 1'b1, 1'b1, 1'b1);
    waitEdges(1);      chkG("R7", 1'b0, 1'b0, 1'b0);
    primaryGood = 1'b1;
    waitEdges(3);      chkG("R2", 1'b1, 1'b0, 1'b0);
    waitEdges(PURST - 2);
    chk("R10", "ready early", ready, 1'b0);
    chkG("R10", 1'b1, 1'b0, 1'b0);
    waitEdges(1);
    chk("R1", "ready back", ready, 1'b1);
    chkG("R10", 1'b1, 1'b0, 1'b0);
    waitEdges(1);      chkG("R10", 1'b1, 1'b0, 1'b1);
    waitEdges(UP);     chkG("R10", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic tVolt();
    ensIn = 1'b0;
    waitEdges(4 + DN + 1); chkG("R4", 1'b1, 1'b0, 1'b0);
    voltMode = 1'b1;
    ensIn = 1'b1;
    waitEdges(8);      chkG("R14", 1'b1, 1'b0, 1'b0);
    setvIn = 1'b1;
    waitEdges(3);      chkG("R5", 1'b1, 1'b0, 1'b0);
    waitEdges(1);      chkG("R5", 1'b1, 1'b0, 1'b1);
    waitEdges(20);     chkG("R5", 1'b1, 1'b0, 1'b1);
    fbAboveRef = 1'b1;
    waitEdges(2);      chkG("R5", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R5", 1'b1, 1'b1, 1'b1);
    ensIn = 1'b0;
    waitEdges(8);      chkG("R14", 1'b1, 1'b1, 1'b1);
    setvIn = 1'b0;
    waitEdges(3);      chkG("R6", 1'b1, 1'b1, 1'b1);
    waitEdges(1);      chkG("R6", 1'b1, 1'b0, 1'b1);
    waitEdges(DN - 1); chkG("R6", 1'b1, 1'b0, 1'b1);
    waitEdges(1);      chkG("R6", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0; voltMode = 1'b0; shutCode = 2'd0;
    primaryGood = 1'b0; ioGood = 1'b0; coreGood = 1'b0;
    ensIn = 1'b0; setvIn = 1'b0; fbAboveRef = 1'b0; primGateEn = 1'b0;
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    tReset();
    tReady();
    tGateH();
    tTimeUp();
    tTimeDown();
    tPending();
    tCodes();
    tIoFail();
    tCoreFail();
    tCollision();
    tPrimFail();
    tVolt();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule